// File: doc/BRIEF.md
# Byte-Wide SPI Master with Mode-Fault Guard

This block is a byte-oriented SPI master that builds its serial clock from the system clock. Software programs a control register (enable, master, clock polarity, clock phase, a two-bit rate field and the slave-select pin configuration). A write to the data register starts a transfer of eight bits on MOSI, most significant bit first, while eight bits are captured from MISO. When the transfer finishes, a completion flag is raised and the received byte can be read from the data register.

The block also watches its own slave-select input through a synchronizer. If that input goes low while the block is enabled as master and the pin is not configured as a general-purpose output, a sticky mode-fault flag is set. The transfer in progress is abandoned, master mode is dropped, and the SCK and MOSI drivers are released. Software clears the fault by reading status and then writing control. A data write while a transfer is running is discarded and flagged as a write collision.

Register map: address 0 is control, address 1 is status (read only), address 2 is data. Register reads are combinational, so read data is valid in the cycle the address is presented.

Top module: `spiByteMaster`

## Requirements
- R1: With control bits 0 (enable) and 1 (master) set and no transfer running, a write to address 2 starts a transfer of exactly 16 SCK edges. The written byte goes out on MOSI most significant bit first. MOSI is low whenever no transfer is running.
- R2: Between transfers SCK sits at control bit 2 (CPOL). The first SCK edge comes one half-period after the cycle that takes the data write.
- R3: Control bit 3 is CPHA. With CPHA=0, each MOSI bit is valid from the start of its bit time, changes on trailing edges, and MISO is captured on leading edges. With CPHA=1, MOSI changes on leading edges from the second one onward, and MISO is captured on trailing edges.
- R4: Control bits 5:4 select the SCK period: 00, 01, 10 and 11 give 2, 4, 16 and 32 system clocks (half-periods of 1, 2, 8 and 16).
- R5: After a transfer, reading address 2 returns the eight captured MISO bits, first-captured bit in bit 7.
- R6: Status bit 0 (done) sets at the clock of the 16th SCK edge. It stays set until a status read that sees it set is followed by a read or write of address 2.
- R7: When the synchronized slave-select input is low while the block is enabled master and control bit 6 is 0, status bit 2 (mode fault) sets. It stays set until a status read that sees it set is followed by a control write. The fault is visible two clocks after the low level is first sampled. No fault arises when master is 0.
- R8: On a mode fault, any running transfer stops, control bit 1 reads 0, and the SCK and MOSI output enables go low. Control writes cannot set bit 1 while the fault flag is set.
- R9: Control bit 6 set configures slave select as a general-purpose output: the pin enable is high, the pin level equals control bit 7, and no mode fault is raised.
- R10: A write to address 2 during a transfer is ignored: the transfer and the received byte are unchanged. The write sets status bit 1 (write collision), which clears the same way as the done flag.
- R11: After reset, control and status read 0, all output enables are low, and SCK and MOSI are low.
- R12: A write to address 2 while the block is not an enabled master starts nothing and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 2 | Register address: 0 control, 1 status, 2 data |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (drives the flag clearing sequences) |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data, combinational from regSel |
| sckOut | output | 1 | Serial clock level |
| sckOe | output | 1 | Serial clock driver enable |
| mosiOut | output | 1 | Serial data out |
| mosiOe | output | 1 | Serial data out driver enable |
| misoIn | input | 1 | Serial data in |
| ssIn | input | 1 | Slave-select pin level seen by the block |
| ssOut | output | 1 | Slave-select level when used as general-purpose output |
| ssOe | output | 1 | Slave-select driver enable |

## Verification
The bench counts from the clock edge that accepts a data write. SCK edge k is due k·half clocks later, so the done flag and the received byte are due 16·half clocks later. A mode fault and the release of the drivers are due two clocks after the first sampled low on slave select. A reference model in the bench steps on each rising edge, using the same inputs the design sees. Pin levels are compared against that model at every falling edge, half a clock after each result settles. Register checks present their strobe half a clock before the edge and read the combinational data after a short settle. Expected register values come only from the requirements.

// File: rtl/spiByteMasterPkg.sv
package spiByteMasterPkg;

  localparam int BYTE_W = 8;

  // SCK period in system clocks for each rate code
  localparam int DIV_R0 = 2;
  localparam int DIV_R1 = 4;
  localparam int DIV_R2 = 16;
  localparam int DIV_R3 = 32;
  localparam int MAX_HALF = DIV_R3 / 2;
  localparam int HALF_W = $clog2(MAX_HALF);

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  localparam int ST_DONE = 0;
  localparam int ST_WCOL = 1;
  localparam int ST_MODF = 2;

  typedef struct packed {
    logic       ssLevel;  // bit 7
    logic       ssGpo;    // bit 6
    logic [1:0] rate;     // bits 5:4
    logic       cpha;     // bit 3
    logic       cpol;     // bit 2
    logic       master;   // bit 1
    logic       enable;   // bit 0
  } ctrlReg_t;

  typedef struct packed {
    logic       start;
    logic       abort;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } dpCmd_t;

  function automatic logic [HALF_W-1:0] halfMinusOne(input logic [1:0] rate);
    case (rate)
      2'b00:   return HALF_W'(DIV_R0 / 2 - 1);
      2'b01:   return HALF_W'(DIV_R1 / 2 - 1);
      2'b10:   return HALF_W'(DIV_R2 / 2 - 1);
      default: return HALF_W'(DIV_R3 / 2 - 1);
    endcase
  endfunction

endpackage

// File: rtl/spiShiftDp.sv
module spiShiftDp
  import spiByteMasterPkg::*;
#(
  parameter int BITS = BYTE_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpCmd_t          cmd,
  input  logic [BITS-1:0] txByte,
  input  logic            misoIn,
  output logic            sckOut,
  output logic            mosiOut,
  output logic            busy,
  output logic            xferDone,
  output logic [BITS-1:0] rxByte
);

  localparam int EDGES  = 2 * BITS;
  localparam int EDGE_W = $clog2(EDGES + 1);

  logic              busyQ;
  logic              sckQ;
  logic              modeCpol;
  logic              modeCpha;
  logic [HALF_W-1:0] divCnt;
  logic [HALF_W-1:0] halfLim;
  logic [EDGE_W-1:0] edgeCnt;
  logic [EDGE_W-1:0] edgeNum;
  logic [BITS-1:0]   txSh;
  logic [BITS-1:0]   rxSh;
  logic [BITS-1:0]   rxNext;
  logic              edgeNow;
  logic              leading;
  logic              capture;
  logic              launch;
  logic              lastEdge;

  always_comb begin
    edgeNow  = busyQ && (divCnt == halfLim);
    edgeNum  = edgeCnt + EDGE_W'(1);
    leading  = edgeNum[0];
    capture  = edgeNow && (modeCpha ? !leading : leading);
    launch   = edgeNow && (modeCpha ? (leading && (edgeNum != EDGE_W'(1)))
                                    : (!leading && (edgeNum != EDGE_W'(EDGES))));
    lastEdge = edgeNow && (edgeNum == EDGE_W'(EDGES));
    rxNext   = {rxSh[BITS-2:0], misoIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      sckQ     <= 1'b0;
      modeCpol <= 1'b0;
      modeCpha <= 1'b0;
      divCnt   <= '0;
      halfLim  <= '0;
      edgeCnt  <= '0;
      txSh     <= '0;
      rxSh     <= '0;
      rxByte   <= '0;
    end else if (cmd.abort) begin
      busyQ   <= 1'b0;
      divCnt  <= '0;
      edgeCnt <= '0;
    end else if (!busyQ) begin
      if (cmd.start) begin
        busyQ    <= 1'b1;
        divCnt   <= '0;
        edgeCnt  <= '0;
        sckQ     <= cmd.cpol;
        modeCpol <= cmd.cpol;
        modeCpha <= cmd.cpha;
        halfLim  <= halfMinusOne(cmd.rate);
        txSh     <= txByte;
        rxSh     <= '0;
      end
    end else begin
      if (edgeNow) begin
        divCnt  <= '0;
        edgeCnt <= edgeNum;
        sckQ    <= ~sckQ;
      end else begin
        divCnt <= divCnt + HALF_W'(1);
      end
      if (capture) rxSh <= rxNext;
      if (launch)  txSh <= {txSh[BITS-2:0], 1'b0};
      if (lastEdge) begin
        busyQ  <= 1'b0;
        rxByte <= modeCpha ? rxNext : rxSh;
      end
    end
  end

  assign busy     = busyQ;
  assign xferDone = lastEdge && !cmd.abort;
  assign sckOut   = busyQ ? sckQ : cmd.cpol;
  assign mosiOut  = busyQ & txSh[BITS-1];

  AST_START_SCK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.start && !busyQ && !cmd.abort) |=> (busy && sckOut == $past(cmd.cpol))); // R2

  AST_END_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (lastEdge && !cmd.abort) |=> (!busy && !mosiOut)); // R1

  AST_MOSI_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !launch && !lastEdge && !cmd.abort) |=> $stable(mosiOut)); // R3

  AST_SCK_MOVES_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !edgeNow && !cmd.abort) |=> $stable(sckOut)); // R4

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (divCnt <= halfLim && edgeCnt < EDGE_W'(EDGES))); // R4

endmodule

// File: rtl/spiRegCtl.sv
module spiRegCtl
  import spiByteMasterPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  input  logic              ssIn,
  output logic              ssOut,
  output logic              ssOe,
  output logic              pinOe,
  output dpCmd_t            cmd,
  input  logic              busy,
  input  logic              xferDone,
  input  logic [BYTE_W-1:0] rxByte
);

  ctrlReg_t ctrlQ;
  ctrlReg_t ctrlNext;
  logic     doneQ;
  logic     wcolQ;
  logic     modfQ;
  logic     flagArm;
  logic     modfArm;
  logic     ssSeen;
  logic     faultNow;
  logic     wrCtrl;
  logic     wrData;
  logic     rdStat;
  logic     rdData;
  logic     dataAcc;
  logic     modfClr;
  logic     flagClr;
  logic     isMaster;

  // Slave-select synchronizer; depth picked by parameter
  generate
    if (SYNC_STAGES <= 1) begin : gSyncOne
      logic ssQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ssQ <= 1'b1;
        else       ssQ <= ssIn;
      end
      assign ssSeen = ssQ;
    end else begin : gSyncChain
      logic [SYNC_STAGES-1:0] ssQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) ssQ <= '1;
        else       ssQ <= {ssQ[SYNC_STAGES-2:0], ssIn};
      end
      assign ssSeen = ssQ[SYNC_STAGES-1];
    end
  endgenerate

  always_comb begin
    wrCtrl   = regWr && (regSel == SEL_CTRL);
    wrData   = regWr && (regSel == SEL_DATA);
    rdStat   = regRd && (regSel == SEL_STAT);
    rdData   = regRd && (regSel == SEL_DATA);
    dataAcc  = wrData || rdData;
    isMaster = ctrlQ.enable && ctrlQ.master;
    faultNow = isMaster && !ctrlQ.ssGpo && !ssSeen;
    modfClr  = wrCtrl && modfArm;
    flagClr  = flagArm && dataAcc;

    ctrlNext = wrCtrl ? ctrlReg_t'(regWdata) : ctrlQ;
    if (faultNow || (modfQ && !modfClr)) ctrlNext.master = 1'b0;

    cmd.start = wrData && isMaster && !modfQ && !busy && !faultNow;
    cmd.abort = faultNow || !isMaster;
    cmd.cpol  = ctrlQ.cpol;
    cmd.cpha  = ctrlQ.cpha;
    cmd.rate  = ctrlQ.rate;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      doneQ   <= 1'b0;
      wcolQ   <= 1'b0;
      modfQ   <= 1'b0;
      flagArm <= 1'b0;
      modfArm <= 1'b0;
    end else begin
      ctrlQ <= ctrlNext;

      if (xferDone)     doneQ <= 1'b1;
      else if (flagClr) doneQ <= 1'b0;

      if (wrData && busy) wcolQ <= 1'b1;
      else if (flagClr)   wcolQ <= 1'b0;

      if (rdStat && (doneQ || wcolQ)) flagArm <= 1'b1;
      else if (dataAcc)               flagArm <= 1'b0;

      if (faultNow)     modfQ <= 1'b1;
      else if (modfClr) modfQ <= 1'b0;

      if (rdStat && modfQ) modfArm <= 1'b1;
      else if (wrCtrl)     modfArm <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regSel)
      SEL_CTRL: regRdata = ctrlQ;
      SEL_STAT: begin
        regRdata[ST_DONE] = doneQ;
        regRdata[ST_WCOL] = wcolQ;
        regRdata[ST_MODF] = modfQ;
      end
      SEL_DATA: regRdata = rxByte;
      default:  regRdata = '0;
    endcase
  end

  assign pinOe = isMaster;
  assign ssOe  = ctrlQ.ssGpo;
  assign ssOut = ctrlQ.ssLevel;

  AST_FAULT_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    faultNow |=> (!pinOe && !busy && modfQ)); // R8

  AST_NO_MASTER_IN_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    modfQ |-> !ctrlQ.master); // R8

  AST_MODF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (modfQ && !(wrCtrl && modfArm)) |=> modfQ); // R7

  AST_GPO_NO_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ.ssGpo && !modfQ) |=> !modfQ); // R9

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !(flagArm && dataAcc)) |=> doneQ); // R6

  AST_WCOL_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (wrData && busy) |=> wcolQ); // R10

  AST_IDLE_WRITE_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (wrData && !isMaster && !busy) |=> !busy); // R12

endmodule

// File: rtl/spiByteMaster.sv
module spiByteMaster
  import spiByteMasterPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  output logic              sckOut,
  output logic              sckOe,
  output logic              mosiOut,
  output logic              mosiOe,
  input  logic              misoIn,
  input  logic              ssIn,
  output logic              ssOut,
  output logic              ssOe
);

  dpCmd_t            cmd;
  logic              busy;
  logic              xferDone;
  logic              pinOe;
  logic [BYTE_W-1:0] rxByte;

  spiRegCtl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) ctlU (
    .clk      (clk),
    .rstN     (rstN),
    .regSel   (regSel),
    .regWr    (regWr),
    .regRd    (regRd),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .ssIn     (ssIn),
    .ssOut    (ssOut),
    .ssOe     (ssOe),
    .pinOe    (pinOe),
    .cmd      (cmd),
    .busy     (busy),
    .xferDone (xferDone),
    .rxByte   (rxByte)
  );

  spiShiftDp #(
    .BITS(BYTE_W)
  ) dpU (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .txByte   (regWdata),
    .misoIn   (misoIn),
    .sckOut   (sckOut),
    .mosiOut  (mosiOut),
    .busy     (busy),
    .xferDone (xferDone),
    .rxByte   (rxByte)
  );

  assign sckOe  = pinOe;
  assign mosiOe = pinOe;

endmodule

// File: tb/spiByteMaster_tb_top.sv
`timescale 1ns/1ps
module spiByteMaster_tb_top;

  localparam int WD_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       sckOut, sckOe, mosiOut, mosiOe, ssOut, ssOe;
  logic       misoIn = 1'b0;
  logic       ssIn = 1'b1;

  int nCmp = 0;
  int nBad = 0;
  bit cmpOn = 1'b0;
  bit runEnd = 1'b0;

  always #4 clk = ~clk;

  spiByteMaster dut_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .sckOut(sckOut), .sckOe(sckOe),
    .mosiOut(mosiOut), .mosiOe(mosiOe), .misoIn(misoIn), .ssIn(ssIn),
    .ssOut(ssOut), .ssOe(ssOe)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit   mBusy = 0, mCpol = 0, mCpha = 0, mDone = 0, mWcol = 0, mModf = 0;
  bit   mArmF = 0, mArmM = 0, ssS0 = 1, ssS1 = 1;
  int   mTick = 0, mHalf = 1;
  logic [7:0] mCtrl = 8'h00, mTx = 8'h00, slaveByte = 8'h00;

  function automatic int halfOf(input logic [1:0] r);
    case (r)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 8;
      default: return 16;
    endcase
  endfunction

  // bit index on the line after e edges have happened
  function automatic int bitIdx(input int e, input bit cpha);
    if (!cpha) return 7 - e / 2;
    if (e == 0) return 7;
    return 7 - (e - 1) / 2;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mWcol = 0; mModf = 0; mArmF = 0; mArmM = 0;
      mCtrl = 8'h00; ssS0 = 1; ssS1 = 1; mTick = 0;
    end else begin
      bit en, fault, cW, dW, sR, dR, oldBusy, doneEvt, clr, mClr;
      logic [7:0] c;
      en      = mCtrl[0] && mCtrl[1];
      fault   = en && !mCtrl[6] && !ssS1;
      cW      = regWr && regSel == 2'd0;
      dW      = regWr && regSel == 2'd2;
      sR      = regRd && regSel == 2'd1;
      dR      = regRd && regSel == 2'd2;
      oldBusy = mBusy;
      doneEvt = 0;
      if (fault || !en) mBusy = 0;
      else if (mBusy) begin
        mTick++;
        if (mTick == 16 * mHalf) begin mBusy = 0; doneEvt = 1; end
      end else if (dW) begin
        mBusy = 1; mTick = 0; mHalf = halfOf(mCtrl[5:4]);
        mCpol = mCtrl[2]; mCpha = mCtrl[3]; mTx = regWdata;
      end
      clr  = mArmF && (dW || dR);
      mClr = cW && mArmM;
      if (doneEvt) mDone = 1; else if (clr) mDone = 0;
      if (dW && oldBusy) mWcol = 1; else if (clr) mWcol = 0;
      if (sR && (mDone || mWcol)) mArmF = 1; else if (dW || dR) mArmF = 0;
      c = cW ? regWdata : mCtrl;
      if (fault || (mModf && !mClr)) c[1] = 1'b0;
      if (fault) mModf = 1; else if (mClr) mModf = 0;
      if (sR && mModf) mArmM = 1; else if (cW) mArmM = 0;
      mCtrl = c;
      ssS1 = ssS0;
      ssS0 = ssIn;
    end
  end

  // per-clock pin comparison and slave MISO drive
  always @(negedge clk) begin
    if (cmpOn) begin
      int e;
      bit eSck, eMosi, eOe;
      e     = mBusy ? mTick / mHalf : 0;
      eSck  = mBusy ? (mCpol ^ e[0]) : mCtrl[2];
      eMosi = mBusy ? mTx[bitIdx(e, mCpha)] : 1'b0;
      eOe   = mCtrl[0] && mCtrl[1];
      chk({7'd0, sckOut}, {7'd0, eSck}, "R2/R4 sck level");
      chk({7'd0, mosiOut}, {7'd0, eMosi}, "R1/R3 mosi bit");
      chk({6'd0, sckOe, mosiOe}, {6'd0, eOe, eOe}, "R8 pin enables");
      chk({6'd0, ssOe, ssOut}, {6'd0, mCtrl[6], mCtrl[7]}, "R9 ss pin");
      misoIn = mBusy ? slaveByte[bitIdx(e, mCpha)] : 1'b0;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wrReg(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    regSel = sel; regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] sel, input logic [7:0] exp, input string tag);
    @(negedge clk);
    regSel = sel; regRd = 1'b1;
    #1;
    chk(regRdata, exp, tag);
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] sl, input int half);
    slaveByte = sl;
    wrReg(2'd2, tx);
    idle(16 * half + 2);
    rdReg(2'd1, 8'h01, "R6 done after 16 edges");
    rdReg(2'd2, sl, "R5 received byte");
    rdReg(2'd1, 8'h00, "R6 done cleared by status+data");
  endtask

  initial begin
    #(WD_CYCLES * 8);
    if (!runEnd) begin
      nCmp++; nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    cmpOn = 1'b1;
    idle(2);

    // R11 reset state
    chk({4'd0, sckOut, sckOe, mosiOut, mosiOe}, 8'h00, "R11 pins after reset");
    rdReg(2'd0, 8'h00, "R11 control after reset");
    rdReg(2'd1, 8'h00, "R11 status after reset");

    // R12 data write while disabled
    wrReg(2'd2, 8'hE7);
    idle(6);
    rdReg(2'd1, 8'h00, "R12 no flag when not master");

    // R1 basic transfer, mode 0, fastest rate
    wrReg(2'd0, 8'h03);
    xfer(8'hA5, 8'h3C, 1);

    // R3 R4 all modes, all rates
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 4; r++) begin
        logic [7:0] cv, tx;
        cv = 8'(r << 4) | 8'(m << 2) | 8'h03;
        tx = 8'(8'h17 + m * 37 + r * 11);
        wrReg(2'd0, cv);
        idle(2);
        rdReg(2'd0, cv, "R3/R4 control readback");
        xfer(tx, ~tx ^ 8'(m), halfOf(2'(r)));
      end
    end

    // R10 write collision
    wrReg(2'd0, 8'h23);
    slaveByte = 8'hC3;
    wrReg(2'd2, 8'h5A);
    idle(10);
    wrReg(2'd2, 8'hFF);
    idle(16 * 8 + 4);
    rdReg(2'd1, 8'h03, "R10 collision and done");
    rdReg(2'd2, 8'hC3, "R10 transfer unaffected");
    rdReg(2'd1, 8'h00, "R10 collision cleared");

    // R7 R8 mode fault mid-transfer
    wrReg(2'd0, 8'h33);
    slaveByte = 8'h81;
    wrReg(2'd2, 8'h42);
    idle(20);
    ssIn = 1'b0;
    idle(4);
    chk({6'd0, sckOe, mosiOe}, 8'h00, "R8 drivers released on fault");
    wrReg(2'd0, 8'h03);
    rdReg(2'd0, 8'h01, "R8 master refused while fault set");
    wrReg(2'd2, 8'h99);
    ssIn = 1'b1;
    idle(4);
    rdReg(2'd1, 8'h04, "R7 fault sticky, R12 nothing else");
    wrReg(2'd0, 8'h03);
    rdReg(2'd0, 8'h03, "R7 master restored after clear");
    rdReg(2'd1, 8'h00, "R7 fault cleared");
    xfer(8'h6E, 8'h1B, 1);

    // R9 slave select as general-purpose output
    wrReg(2'd0, 8'hC3);
    idle(1);
    chk({6'd0, ssOe, ssOut}, 8'h03, "R9 ss pin driven");
    ssIn = 1'b0;
    xfer(8'h96, 8'h69, 1);
    ssIn = 1'b1;

    // R7 no fault when not master
    wrReg(2'd0, 8'h01);
    ssIn = 1'b0;
    idle(6);
    rdReg(2'd1, 8'h00, "R7 no fault when not master");
    ssIn = 1'b1;
    idle(4);

    runEnd = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule